// File: doc/BRIEF.md
# Power-Up Self-Test LED Sequencer

This block runs a fixed self-test sequence as soon as reset is released. It acts as a simple bus master. It issues one read or write at a time and waits for an acknowledge from the addressed slave. If no acknowledge arrives within a configurable number of cycles, the transfer counts as a timeout. Three check indicators are lit from reset. Each one is put out only when its own check passes, so a board that stops mid-test still shows which checks have not yet passed.

The sequence has three checks, run in a fixed order:
- **Control check:** writes a known pattern to the processor error register and reads it back.
- **Console check:** probes the console serial receiver.
- **Memory check:** requires two results. A read of location zero must succeed, and a read of a reserved address must time out.

A failed check does not stop the sequence. Once all transfers are done, the block raises a done flag and an overall pass flag. A fourth indicator shows whether the processor is in console monitor mode. This indicator is independent of the test.

Top module: `pst_led_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the three check indicators (control, console, memory) are lit, test_done_o and test_pass_o are 0 and bus_req_o is 0. With LED_ACTIVE_HIGH=1, lit means the output is 1.
- R2: Between resets, a check indicator that has gone out never lights again. A failed check leaves its indicator lit.
- R3: After reset the block issues exactly five transfers, in this order, whether or not earlier checks failed:
  - write ERR_ADDR (default octal 17777766) with PATTERN (default 0x00A5);
  - read ERR_ADDR;
  - read CON_ADDR (octal 17777560);
  - read MEM_ADDR (0);
  - read RSV_ADDR (octal 17777700).
- R4: The control indicator goes out only if the write is acknowledged and the readback is acknowledged with data exactly equal to PATTERN.
- R5: The console indicator goes out only if the read of CON_ADDR is acknowledged.
- R6: The memory indicator goes out only if the read of MEM_ADDR is acknowledged and the read of RSV_ADDR times out.
- R7: A transfer with no acknowledge holds bus_req_o high for exactly TMO_CYCLES cycles (default 64), then drops it and counts the transfer as a timeout.
- R8: led_mon_o equals mon_mode_i (the indicator polarity is applied) in the same cycle, at all times, including during reset.
- R9: test_done_o rises after the fifth transfer ends and stays high until reset, with no further transfers. test_pass_o is 1 exactly when test_done_o is 1 and all three check indicators are out.
- R10: While bus_req_o is high, bus_addr_o, bus_we_o and bus_wdata_o are stable. A transfer acknowledged in the k-th cycle of its request holds bus_req_o for exactly k cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; test restarts on release |
| mon_mode_i | input | 1 | Processor is in console monitor mode |
| bus_req_o | output | 1 | Transfer request, held until acknowledge or timeout |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW (22) | Transfer address |
| bus_wdata_o | output | DW (16) | Write data |
| bus_ack_i | input | 1 | Slave acknowledge, sampled while bus_req_o is high |
| bus_rdata_i | input | DW (16) | Read data, valid with bus_ack_i |
| led_mon_o | output | 1 | Monitor mode indicator |
| led_ctl_o | output | 1 | Control check indicator |
| led_con_o | output | 1 | Console check indicator |
| led_mem_o | output | 1 | Memory check indicator |
| test_done_o | output | 1 | Sequence finished (sticky) |
| test_pass_o | output | 1 | All three checks passed |

## Verification
The bench uses a bus slave model. Each test case changes the model in one way:
- **All good:** every slave responds correctly.
- **Missing console:** the console slave gives no acknowledge.
- **Reserved address answers:** a slave acknowledges the reserved address.
- **Memory absent:** the read of location zero times out.
- **Corrupted readback:** the error register returns different data.
- **Error register missing:** the error register write times out.
- **Everything silent:** no slave responds.

Each of these cases should leave exactly one known set of indicators lit, except the all-good case, which leaves none. Together they separate the control, console and memory pass rules from each other. They also show that the memory check needs both of its reads. The silent case also shows that every check still runs after earlier failures, and that each timeout lasts the full window.

// File: rtl/pst_pkg.sv
package pst_pkg;

   typedef enum logic [2:0] {
      STP_WR_ERR = 3'd0,
      STP_RD_ERR = 3'd1,
      STP_RD_CON = 3'd2,
      STP_RD_MEM = 3'd3,
      STP_RD_RSV = 3'd4,
      STP_FIN    = 3'd5
   } step_e;

   function automatic step_e next_step(input step_e s);
      case (s)
         STP_WR_ERR: return STP_RD_ERR;
         STP_RD_ERR: return STP_RD_CON;
         STP_RD_CON: return STP_RD_MEM;
         STP_RD_MEM: return STP_RD_RSV;
         default:    return STP_FIN;
      endcase
   endfunction

endpackage

// File: rtl/pst_bus_xfer.sv
module pst_bus_xfer #(
   parameter int AW  = 22,
   parameter int DW  = 16,
   parameter int TMO = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          ok_o,
   output logic [DW-1:0] rdata_o,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic          bus_ack_i,
   input  logic [DW-1:0] bus_rdata_i
);
   localparam int CW = $clog2(TMO + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(TMO - 1);

   generate
      if (TMO < 2) begin : g_bad_tmo
         $error("pst_bus_xfer: TMO must be at least 2");
      end
   endgenerate

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         cnt_q       <= '0;
         done_o      <= 1'b0;
         ok_o        <= 1'b0;
         rdata_o     <= '0;
         bus_we_o    <= 1'b0;
         bus_addr_o  <= '0;
         bus_wdata_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (!busy_q) begin
            if (go_i) begin
               busy_q      <= 1'b1;
               cnt_q       <= '0;
               bus_we_o    <= we_i;
               bus_addr_o  <= addr_i;
               bus_wdata_o <= wdata_i;
            end
         end else if (bus_ack_i) begin
            busy_q  <= 1'b0;
            done_o  <= 1'b1;
            ok_o    <= 1'b1;
            rdata_o <= bus_rdata_i;
         end else if (cnt_q == CNT_LAST) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
            ok_o   <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy_o    = busy_q;
   assign bus_req_o = busy_q;

   // R7: a request left unanswered for the full window is released
   a_r7_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !bus_ack_i && cnt_q == CNT_LAST) |=> (!busy_q && done_o && !ok_o));

   // R10: transfer fields hold while the request is pending
   a_r10_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !bus_ack_i && cnt_q != CNT_LAST) |=>
         ($stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

   // R10: an acknowledge ends the request on the next edge
   a_r10_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bus_ack_i) |=> (!busy_q && done_o && ok_o));

endmodule

// File: rtl/pst_seq.sv
module pst_seq
   import pst_pkg::*;
#(
   parameter int          AW       = 22,
   parameter int          DW       = 16,
   parameter logic [AW-1:0] ERR_ADDR = 22'o17777766,
   parameter logic [AW-1:0] CON_ADDR = 22'o17777560,
   parameter logic [AW-1:0] MEM_ADDR = 22'o0,
   parameter logic [AW-1:0] RSV_ADDR = 22'o17777700,
   parameter logic [DW-1:0] PATTERN  = 16'h00A5
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          go_o,
   output logic          we_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   input  logic          xfer_busy_i,
   input  logic          done_i,
   input  logic          ok_i,
   input  logic [DW-1:0] rdata_i,
   output logic          ctl_lit_o,
   output logic          con_lit_o,
   output logic          mem_lit_o,
   output logic          fin_o,
   output logic          pass_o
);
   step_e step_q;
   logic  issued_q;
   logic  wr_ok_q;
   logic  mem0_ok_q;

   assign go_o    = !issued_q && (step_q != STP_FIN);
   assign we_o    = (step_q == STP_WR_ERR);
   assign wdata_o = PATTERN;

   always_comb begin
      case (step_q)
         STP_WR_ERR, STP_RD_ERR: addr_o = ERR_ADDR;
         STP_RD_CON:             addr_o = CON_ADDR;
         STP_RD_MEM:             addr_o = MEM_ADDR;
         default:                addr_o = RSV_ADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q    <= STP_WR_ERR;
         issued_q  <= 1'b0;
         wr_ok_q   <= 1'b0;
         mem0_ok_q <= 1'b0;
         ctl_lit_o <= 1'b1;
         con_lit_o <= 1'b1;
         mem_lit_o <= 1'b1;
         fin_o     <= 1'b0;
      end else if (go_o) begin
         issued_q <= 1'b1;
      end else if (issued_q && done_i) begin
         issued_q <= 1'b0;
         step_q   <= next_step(step_q);
         case (step_q)
            STP_WR_ERR: wr_ok_q <= ok_i;
            STP_RD_ERR: if (wr_ok_q && ok_i && rdata_i == PATTERN) ctl_lit_o <= 1'b0;
            STP_RD_CON: if (ok_i) con_lit_o <= 1'b0;
            STP_RD_MEM: mem0_ok_q <= ok_i;
            STP_RD_RSV: begin
               if (mem0_ok_q && !ok_i) mem_lit_o <= 1'b0;
               fin_o <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign pass_o = fin_o && !ctl_lit_o && !con_lit_o && !mem_lit_o;

   // R2: an indicator that went out stays out until reset
   a_r2_ctl_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_lit_o |=> !ctl_lit_o);
   a_r2_con_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
      !con_lit_o |=> !con_lit_o);
   a_r2_mem_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_lit_o |=> !mem_lit_o);

   // R9: completion is sticky and issues nothing further
   a_r9_fin_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> (fin_o && !go_o));

   // R3: a new transfer is only requested when the bus engine is idle
   a_r3_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      go_o |-> !xfer_busy_i);

endmodule

// File: rtl/pst_led_seq.sv
module pst_led_seq #(
   parameter int            AW              = 22,
   parameter int            DW              = 16,
   parameter int            TMO_CYCLES      = 64,
   parameter bit            LED_ACTIVE_HIGH = 1'b1,
   parameter logic [AW-1:0] ERR_ADDR        = 22'o17777766,
   parameter logic [AW-1:0] CON_ADDR        = 22'o17777560,
   parameter logic [AW-1:0] MEM_ADDR        = 22'o0,
   parameter logic [AW-1:0] RSV_ADDR        = 22'o17777700,
   parameter logic [DW-1:0] PATTERN         = 16'h00A5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mon_mode_i,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic          bus_ack_i,
   input  logic [DW-1:0] bus_rdata_i,
   output logic          led_mon_o,
   output logic          led_ctl_o,
   output logic          led_con_o,
   output logic          led_mem_o,
   output logic          test_done_o,
   output logic          test_pass_o
);
   generate
      if (AW < 22) begin : g_bad_aw
         $error("pst_led_seq: AW must hold the probe addresses");
      end
      if (DW < 8) begin : g_bad_dw
         $error("pst_led_seq: DW too narrow");
      end
   endgenerate

   logic          go, we, busy, done, ok;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rdata;
   logic          ctl_lit, con_lit, mem_lit;

   pst_seq #(
      .AW(AW), .DW(DW), .ERR_ADDR(ERR_ADDR), .CON_ADDR(CON_ADDR),
      .MEM_ADDR(MEM_ADDR), .RSV_ADDR(RSV_ADDR), .PATTERN(PATTERN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .go_o(go), .we_o(we), .addr_o(addr), .wdata_o(wdata),
      .xfer_busy_i(busy), .done_i(done), .ok_i(ok), .rdata_i(rdata),
      .ctl_lit_o(ctl_lit), .con_lit_o(con_lit), .mem_lit_o(mem_lit),
      .fin_o(test_done_o), .pass_o(test_pass_o)
   );

   pst_bus_xfer #(.AW(AW), .DW(DW), .TMO(TMO_CYCLES)) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .go_i(go), .we_i(we), .addr_i(addr), .wdata_i(wdata),
      .busy_o(busy), .done_o(done), .ok_o(ok), .rdata_o(rdata),
      .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i)
   );

   generate
      if (LED_ACTIVE_HIGH) begin : g_led_hi
         assign led_mon_o = mon_mode_i;
         assign led_ctl_o = ctl_lit;
         assign led_con_o = con_lit;
         assign led_mem_o = mem_lit;
      end else begin : g_led_lo
         assign led_mon_o = ~mon_mode_i;
         assign led_ctl_o = ~ctl_lit;
         assign led_con_o = ~con_lit;
         assign led_mem_o = ~mem_lit;
      end
   endgenerate

   // R9: overall pass only once done and with every check indicator out
   a_r9_pass_rule: assert property (@(posedge clk) disable iff (!rst_n)
      test_pass_o |-> (test_done_o && !ctl_lit && !con_lit && !mem_lit));

   // R1: the first cycle out of reset shows all checks pending
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (ctl_lit && con_lit && mem_lit && !test_done_o && !bus_req_o));

endmodule

// File: tb/sim_pst_led_seq.sv
module sim_pst_led_seq;
   localparam int AW = 22;
   localparam int DW = 16;
   localparam int TMO = 64;
   localparam int LAT = 2;
   localparam logic [AW-1:0] A_ERR = 22'o17777766;
   localparam logic [AW-1:0] A_CON = 22'o17777560;
   localparam logic [AW-1:0] A_MEM = 22'o0;
   localparam logic [AW-1:0] A_RSV = 22'o17777700;
   localparam logic [DW-1:0] PAT   = 16'h00A5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mon_mode = 1'b0;
   logic          bus_req, bus_we, bus_ack;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic          led_mon, led_ctl, led_con, led_mem, t_done, t_pass;

   always #4 clk = ~clk;

   pst_led_seq u0 (
      .clk(clk), .rst_n(rst_n), .mon_mode_i(mon_mode),
      .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
      .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
      .led_mon_o(led_mon), .led_ctl_o(led_ctl), .led_con_o(led_con),
      .led_mem_o(led_mem), .test_done_o(t_done), .test_pass_o(t_pass)
   );

   // ---- slave model configuration ----
   logic          s_err_ok, s_err_bad, s_con, s_mem, s_rsv;
   logic [DW-1:0] err_reg;
   int            s_cnt;

   function automatic logic responds(input logic [AW-1:0] a);
      if (a == A_ERR) return s_err_ok;
      if (a == A_CON) return s_con;
      if (a == A_MEM) return s_mem;
      if (a == A_RSV) return s_rsv;
      return 1'b0;
   endfunction

   assign bus_ack   = bus_req && responds(bus_addr) && (s_cnt == LAT);
   assign bus_rdata = (bus_addr == A_ERR) ? (err_reg ^ (s_err_bad ? 16'h0100 : 16'h0000))
                                          : 16'h1234;

   always @(posedge clk) begin
      if (!bus_req) s_cnt <= 0;
      else s_cnt <= s_cnt + 1;
      if (bus_ack && bus_we && bus_addr == A_ERR) err_reg <= bus_wdata;
   end

   // ---- scoreboard ----
   typedef struct {
      logic [AW-1:0] addr;
      logic          we;
      logic [DW-1:0] wdata;
      int            len;
   } bus_exp_t;

   typedef struct {
      logic ctl, con, mem, pass;
   } res_exp_t;

   bus_exp_t bq[$];
   res_exp_t rq[$];

   int errors = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor
   logic     req_prev = 1'b0, done_prev = 1'b0;
   logic     ctl_prev = 1'b1, con_prev = 1'b1, mem_prev = 1'b1;
   int       len_cnt = 0;
   bus_exp_t cur;
   logic [AW-1:0] held_addr;

   always @(negedge clk) begin
      if (!rst_n) begin
         req_prev  <= 1'b0;
         done_prev <= 1'b0;
         ctl_prev  <= 1'b1;
         con_prev  <= 1'b1;
         mem_prev  <= 1'b1;
         len_cnt   <= 0;
      end else begin
         if (bus_req && !req_prev) begin
            if (bq.size() == 0) begin
               chk(0, "R3", "unexpected transfer addr", bus_addr, 0);
            end else begin
               cur = bq.pop_front();
               chk(bus_addr == cur.addr, "R3", "transfer addr", bus_addr, cur.addr);
               chk(bus_we == cur.we, "R3", "transfer we", bus_we, cur.we);
               if (cur.we) chk(bus_wdata == cur.wdata, "R3", "write data", bus_wdata, cur.wdata);
            end
            held_addr = bus_addr;
            len_cnt <= 1;
         end else if (bus_req) begin
            if (bus_addr != held_addr)
               chk(0, "R10", "addr changed mid-request", bus_addr, held_addr);
            len_cnt <= len_cnt + 1;
         end else if (req_prev) begin
            // R7 (timeouts) and R10 (acknowledged) request length
            chk(len_cnt == cur.len, (cur.len == TMO) ? "R7" : "R10",
                "request length", len_cnt, cur.len);
         end
         req_prev <= bus_req;

         if ((led_ctl && !ctl_prev) || (led_con && !con_prev) || (led_mem && !mem_prev))
            chk(0, "R2", "indicator relit", {led_ctl, led_con, led_mem},
                {ctl_prev, con_prev, mem_prev});
         ctl_prev <= led_ctl;
         con_prev <= led_con;
         mem_prev <= led_mem;

         if (t_done && !done_prev) begin
            if (rq.size() == 0) begin
               chk(0, "R9", "unexpected done", 1, 0);
            end else begin
               res_exp_t r;
               r = rq.pop_front();
               chk(led_ctl == r.ctl, "R4", "control indicator", led_ctl, r.ctl);
               chk(led_con == r.con, "R5", "console indicator", led_con, r.con);
               chk(led_mem == r.mem, "R6", "memory indicator", led_mem, r.mem);
               chk(t_pass == r.pass, "R9", "pass flag", t_pass, r.pass);
            end
         end
         done_prev <= t_done;
      end
   end

   // ---- driver ----
   function automatic int lenof(input logic resp);
      return resp ? LAT + 1 : TMO;
   endfunction

   task automatic run_case(input string name, input logic e_ok, input logic e_bad,
                           input logic con, input logic mem, input logic rsv);
      res_exp_t r;
      bus_exp_t b;
      @(negedge clk);
      rst_n = 1'b0;
      s_err_ok = e_ok; s_err_bad = e_bad; s_con = con; s_mem = mem; s_rsv = rsv;
      err_reg = '0;
      repeat (2) @(negedge clk);
      chk({led_ctl, led_con, led_mem} == 3'b111, "R1", {name, " lit in reset"},
          {led_ctl, led_con, led_mem}, 3'b111);
      chk(!t_done && !t_pass && !bus_req, "R1", {name, " idle in reset"},
          {t_done, t_pass, bus_req}, 0);
      b.addr = A_ERR; b.we = 1; b.wdata = PAT; b.len = lenof(e_ok); bq.push_back(b);
      b.addr = A_ERR; b.we = 0; b.wdata = 0;   b.len = lenof(e_ok); bq.push_back(b);
      b.addr = A_CON; b.len = lenof(con); bq.push_back(b);
      b.addr = A_MEM; b.len = lenof(mem); bq.push_back(b);
      b.addr = A_RSV; b.len = lenof(rsv); bq.push_back(b);
      r.ctl  = !(e_ok && !e_bad);
      r.con  = !con;
      r.mem  = !(mem && !rsv);
      r.pass = !r.ctl && !r.con && !r.mem;
      rq.push_back(r);
      rst_n = 1'b1;
      @(negedge clk);
      chk({led_ctl, led_con, led_mem} == 3'b111 && !t_done, "R1",
          {name, " first cycle after reset"}, {led_ctl, led_con, led_mem, t_done}, 4'b1110);
      for (int i = 0; i < 2000 && !t_done; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(bq.size() == 0, "R3", {name, " transfers left unissued"}, bq.size(), 0);
      chk(rq.size() == 0, "R9", {name, " done not seen"}, rq.size(), 0);
      chk(t_done && !bus_req, "R9", {name, " done sticky, bus quiet"}, {t_done, bus_req}, 2'b10);
      bq.delete();
      rq.delete();
   endtask

   initial begin
      s_err_ok = 1; s_err_bad = 0; s_con = 1; s_mem = 1; s_rsv = 0; err_reg = '0;
      // R8: monitor indicator follows input, even in reset
      @(negedge clk);
      mon_mode = 1'b1; #1;
      chk(led_mon == 1'b1, "R8", "monitor on in reset", led_mon, 1);
      run_case("all_good",     1, 0, 1, 1, 0);
      mon_mode = 1'b0; #1;
      chk(led_mon == 1'b0, "R8", "monitor off after test", led_mon, 0);
      mon_mode = 1'b1; #1;
      chk(led_mon == 1'b1, "R8", "monitor on after test", led_mon, 1);
      mon_mode = 1'b0;
      run_case("no_console",   1, 0, 0, 1, 0);
      run_case("rsv_answers",  1, 0, 1, 1, 1);
      run_case("no_memory",    1, 0, 1, 0, 0);
      run_case("bad_readback", 1, 1, 1, 1, 0);
      run_case("no_err_reg",   0, 0, 1, 1, 0);
      run_case("all_silent",   0, 0, 0, 0, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule